// File: doc/BRIEF.md
# Core Instruction Dispatch Throttle

This block decides, every clock cycle, whether a two-thread processor core may dispatch instructions. A small programmable limiter and a hardware thermal guard each produce their own allow signal. The core only dispatches in cycles where both signals agree. The limiter works in one of two programmed modes.

- **Duty-cycle mode** counts cycles. It opens dispatch for a programmed number of cycles, then shuts it for another programmed number, and repeats.
- **Instruction-cap mode** splits time into windows of a programmed number of cycles. It lets at most a programmed number of instructions, summed over both threads, through in each window.

Both modes use the same two 16-bit configuration values. Either value may be rewritten at any time, and the change takes effect without a reset.

The thermal guard reacts to a critical-temperature input on its own. It clamps dispatch to one allowed cycle in every eight. Once the temperature drops below the warning level, it raises the duty step by step back to full rate.

The limiter has two states, `RH_RUN` and `RH_HOLD`. It moves from `RH_RUN` to `RH_HOLD` when its run count expires, and back to `RH_RUN` when its hold count expires. It returns to `RH_RUN` with a cleared count whenever it is idle.

The cap counter has two states, `CAP_IDLE` and `CAP_COUNT`. It moves from `CAP_IDLE` to `CAP_COUNT` when cap mode is selected with a nonzero window. It goes back to `CAP_IDLE` when that condition ends.

The thermal guard has three states:
- `EM_NORMAL` moves to `EM_CLAMP` when the critical input is high.
- `EM_CLAMP` moves to `EM_RAMP` once both temperature inputs are low.
- `EM_RAMP` goes back to `EM_CLAMP` whenever the critical input is high. It moves to `EM_NORMAL` after the interval at full duty has elapsed.

A throttled-cycle strobe marks every blocked cycle, for use by a utilization counter. Two flags report whether the guard is engaged and whether the instruction cap has been reached.

Top module: `dispatch_throttle`

## Requirements
- R1: `mode_sel` selects the programmed mode: 0 = off, 1 = duty-cycle, 2 = instruction-cap, and 3 behaves as off. With the mode off and the guard in `EM_NORMAL`, `dispatch_allow` is 1, including after reset.
- R2: In duty-cycle mode with both values nonzero, dispatch is allowed for `run_len` cycles and then blocked for `hold_len` cycles, repeating. The first cycle spent in the mode is an allowed cycle.
- R3: Duty-cycle throttling counts cycles only. The strobes on `disp_stb` and `cmpl_stb` have no effect on when the run and hold periods occur.
- R4: In duty-cycle mode, `hold_len` = 0 means no throttling, and `run_len` = 0 with a nonzero `hold_len` blocks every cycle. If a rewritten length is already reached or passed by the current count, the current period ends after that cycle.
- R5: In instruction-cap mode, `hold_len` is the window length Y and `run_len` is the cap Z. `dispatch_allow` is 1 while the count of events so far in the window is below Z. The window begins on the first cycle in the mode. Events in the last cycle of a window are discarded, and the count restarts from zero at the start of each window.
- R6: `cap_src` = 0 counts the set bits of `disp_stb`; `cap_src` = 1 counts the set bits of `cmpl_stb`. The unselected strobes have no effect. Both threads add to one shared count.
- R7: In instruction-cap mode, Y = 0 means no throttling, and Z = 0 with a nonzero Y blocks every cycle.
- R8: When `temp_crit` is 1 at a clock edge in `EM_NORMAL`, the guard enters `EM_CLAMP` at that edge. There it allows only the last cycle of each eight-cycle frame, so the first seven cycles after entry are blocked.
- R9: Once both `temp_crit` and `temp_warn` are low, the guard ramps the duty from 1/8 to 8/8. It adds one step after every `RAMP_INTERVAL` cycles with both inputs low; in a frame at step s, the last s cycles are allowed. While `temp_warn` is 1 the ramp is frozen. A 1 on `temp_crit` returns the guard to the clamp at step 1. After a full interval at step 8 the guard returns to `EM_NORMAL`.
- R10: `dispatch_allow` is 1 only when both the programmed mode and the thermal guard allow the cycle.
- R11: `throttled_cycle` is 1 in exactly the cycles where `dispatch_allow` is 0.
- R12: `emerg_active` is 1 whenever the guard is outside `EM_NORMAL`. `cap_reached` is 1 only in instruction-cap mode with nonzero Y and a window count at or above Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Programmed mode: 0 off, 1 duty-cycle, 2 instruction-cap, 3 off |
| run_len | input | CNT_W | Run cycles (duty-cycle) or instruction cap Z (instruction-cap) |
| hold_len | input | CNT_W | Hold cycles (duty-cycle) or window length Y (instruction-cap) |
| cap_src | input | 1 | Cap counting source: 0 dispatch strobes, 1 completion strobes |
| disp_stb | input | NUM_THREADS | Per-thread dispatch strobe |
| cmpl_stb | input | NUM_THREADS | Per-thread completion strobe |
| temp_crit | input | 1 | Critical temperature reached |
| temp_warn | input | 1 | Temperature at or above warning level |
| dispatch_allow | output | 1 | Dispatch may proceed this cycle |
| throttled_cycle | output | 1 | This cycle is blocked |
| emerg_active | output | 1 | Thermal guard engaged |
| cap_reached | output | 1 | Instruction cap reached in the current window |

## Verification
The assertions assume the temperature inputs are synchronous levels. They also assume that `run_len`, `hold_len` and `mode_sel` change only between clock edges, so one edge never sees a half-written value. The bench drives every input at the falling clock edge. It changes the configuration only in that phase, sometimes in the middle of a run or hold period, so a rewrite is always a clean value for a whole cycle. The strobes come from a shift-register sequence that is unrelated to `dispatch_allow`. The thermal inputs step through the critical, warning and cool levels, including a critical pulse in the middle of a ramp.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_RUNHOLD = 2'd1,
        MODE_CAP     = 2'd2,
        MODE_RSVD    = 2'd3
    } thr_mode_e;

    typedef enum logic {
        RH_RUN  = 1'b0,
        RH_HOLD = 1'b1
    } rh_state_e;

    typedef enum logic {
        CAP_IDLE  = 1'b0,
        CAP_COUNT = 1'b1
    } cap_state_e;

    typedef enum logic [1:0] {
        EM_NORMAL = 2'd0,
        EM_CLAMP  = 2'd1,
        EM_RAMP   = 2'd2
    } em_state_e;
endpackage

// File: rtl/thr_runhold.sv
`timescale 1ns/1ps
module thr_runhold
    import thr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] hold_len,
    output logic             allow
);
    rh_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             idle;

    assign idle = !en || (run_len == '0) || (hold_len == '0);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + 1'b1;
        unique case (st_q)
            RH_RUN: begin
                if (idle) begin
                    st_d  = RH_RUN;
                    cnt_d = '0;
                end else if (cnt_q >= run_len - 1'b1) begin
                    st_d  = RH_HOLD;
                    cnt_d = '0;
                end
            end
            RH_HOLD: begin
                if (idle) begin
                    st_d  = RH_RUN;
                    cnt_d = '0;
                end else if (cnt_q >= hold_len - 1'b1) begin
                    st_d  = RH_RUN;
                    cnt_d = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RH_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        if (hold_len == '0)     allow = 1'b1;
        else if (run_len == '0) allow = 1'b0;
        else                    allow = (st_q == RH_RUN);
    end

    // R2: an expired run period is always followed by a hold period
    p_run_to_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_len != '0 && hold_len != '0 && st_q == RH_RUN && cnt_q >= run_len - 1'b1)
        |=> (st_q == RH_HOLD));
endmodule

// File: rtl/thr_icap.sv
`timescale 1ns/1ps
module thr_icap
    import thr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NTHR  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] cap_lim,
    input  logic             src_cmpl,
    input  logic [NTHR-1:0]  disp_stb,
    input  logic [NTHR-1:0]  cmpl_stb,
    output logic             allow,
    output logic             reached
);
    localparam int EV_W = $clog2(NTHR + 1);

    cap_state_e       st_q, st_d;
    logic [CNT_W-1:0] wcnt_q, wcnt_d;
    logic [CNT_W-1:0] icnt_q, icnt_d;
    logic [NTHR-1:0]  sel;
    logic [EV_W-1:0]  ev;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;
    logic             idle;
    logic             wrap;

    assign idle = !en || (win_len == '0);
    assign sel  = src_cmpl ? cmpl_stb : disp_stb;
    assign wrap = (wcnt_q >= win_len - 1'b1);

    always_comb begin
        ev = '0;
        for (int i = 0; i < NTHR; i++) ev = ev + EV_W'(sel[i]);
    end

    assign sum = {1'b0, icnt_q} + (CNT_W+1)'(ev);
    assign sat = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

    always_comb begin
        st_d   = st_q;
        wcnt_d = wcnt_q;
        icnt_d = icnt_q;
        unique case (st_q)
            CAP_IDLE, CAP_COUNT: begin
                if (idle) begin
                    st_d   = CAP_IDLE;
                    wcnt_d = '0;
                    icnt_d = '0;
                end else begin
                    st_d = CAP_COUNT;
                    if (wrap) begin
                        wcnt_d = '0;
                        icnt_d = '0;
                    end else begin
                        wcnt_d = wcnt_q + 1'b1;
                        icnt_d = sat;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CAP_IDLE;
            wcnt_q <= '0;
            icnt_q <= '0;
        end else begin
            st_q   <= st_d;
            wcnt_q <= wcnt_d;
            icnt_q <= icnt_d;
        end
    end

    always_comb begin
        allow   = idle ? 1'b1 : (icnt_q < cap_lim);
        reached = !idle && (icnt_q >= cap_lim);
    end

    // R5: the window counter restarts after its last cycle
    p_window_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && wcnt_q >= win_len - 1'b1) |=> (wcnt_q == '0));
endmodule

// File: rtl/thr_emerg.sv
`timescale 1ns/1ps
module thr_emerg
    import thr_pkg::*;
#(
    parameter int STEPS    = 8,
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_crit,
    input  logic temp_warn,
    output logic allow,
    output logic active
);
    localparam int STEP_W = $clog2(STEPS + 1);
    localparam int PH_W   = $clog2(STEPS);
    localparam int TMR_W  = $clog2(INTERVAL);

    em_state_e         st_q, st_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic [STEP_W-1:0] ph_ext;

    assign ph_ext = STEP_W'(ph_q);

    always_comb begin
        st_d   = st_q;
        step_d = step_q;
        tmr_d  = tmr_q;
        ph_d   = (ph_q == PH_W'(STEPS - 1)) ? '0 : ph_q + 1'b1;
        unique case (st_q)
            EM_NORMAL: begin
                ph_d = '0;
                if (temp_crit) begin
                    st_d   = EM_CLAMP;
                    step_d = STEP_W'(1);
                    tmr_d  = '0;
                end
            end
            EM_CLAMP: begin
                if (!temp_crit && !temp_warn) begin
                    st_d  = EM_RAMP;
                    tmr_d = '0;
                end
            end
            EM_RAMP: begin
                if (temp_crit) begin
                    st_d   = EM_CLAMP;
                    step_d = STEP_W'(1);
                    tmr_d  = '0;
                end else if (!temp_warn) begin
                    if (tmr_q == TMR_W'(INTERVAL - 1)) begin
                        tmr_d = '0;
                        if (step_q == STEP_W'(STEPS)) begin
                            st_d = EM_NORMAL;
                            ph_d = '0;
                        end else begin
                            step_d = step_q + 1'b1;
                        end
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
            end
            default: st_d = EM_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= EM_NORMAL;
            step_q <= STEP_W'(1);
            ph_q   <= '0;
            tmr_q  <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            ph_q   <= ph_d;
            tmr_q  <= tmr_d;
        end
    end

    always_comb begin
        unique case (st_q)
            EM_NORMAL: begin
                allow  = 1'b1;
                active = 1'b0;
            end
            default: begin
                allow  = (ph_ext >= STEP_W'(STEPS) - step_q);
                active = 1'b1;
            end
        endcase
    end

    // R8: a critical temperature always leaves the guard engaged next cycle
    p_crit_engage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        temp_crit |=> active);

    // R9: the duty step does not move while the warning level is held
    p_warn_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == EM_RAMP && temp_warn && !temp_crit) |=> $stable(step_q));
endmodule

// File: rtl/dispatch_throttle.sv
`timescale 1ns/1ps
module dispatch_throttle
    import thr_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int NUM_THREADS   = 2,
    parameter int RAMP_STEPS    = 8,
    parameter int RAMP_INTERVAL = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_sel,
    input  logic [CNT_W-1:0]       run_len,
    input  logic [CNT_W-1:0]       hold_len,
    input  logic                   cap_src,
    input  logic [NUM_THREADS-1:0] disp_stb,
    input  logic [NUM_THREADS-1:0] cmpl_stb,
    input  logic                   temp_crit,
    input  logic                   temp_warn,
    output logic                   dispatch_allow,
    output logic                   throttled_cycle,
    output logic                   emerg_active,
    output logic                   cap_reached
);
    thr_mode_e mode;
    logic      rh_en, cap_en;
    logic      rh_allow, cap_allow, em_allow, prog_allow;

    assign mode   = thr_mode_e'(mode_sel);
    assign rh_en  = (mode == MODE_RUNHOLD);
    assign cap_en = (mode == MODE_CAP);

    thr_runhold #(.CNT_W(CNT_W)) u_runhold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rh_en),
        .run_len  (run_len),
        .hold_len (hold_len),
        .allow    (rh_allow)
    );

    thr_icap #(.CNT_W(CNT_W), .NTHR(NUM_THREADS)) u_icap (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cap_en),
        .win_len  (hold_len),
        .cap_lim  (run_len),
        .src_cmpl (cap_src),
        .disp_stb (disp_stb),
        .cmpl_stb (cmpl_stb),
        .allow    (cap_allow),
        .reached  (cap_reached)
    );

    thr_emerg #(.STEPS(RAMP_STEPS), .INTERVAL(RAMP_INTERVAL)) u_emerg (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_crit (temp_crit),
        .temp_warn (temp_warn),
        .allow     (em_allow),
        .active    (emerg_active)
    );

    always_comb begin
        unique case (mode)
            MODE_RUNHOLD: prog_allow = rh_allow;
            MODE_CAP:     prog_allow = cap_allow;
            default:      prog_allow = 1'b1;
        endcase
    end

    assign dispatch_allow  = prog_allow & em_allow;
    assign throttled_cycle = ~dispatch_allow;

    // R1: with no programmed mode and no emergency, dispatch is never blocked
    p_off_passes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == 2'd0 || mode_sel == 2'd3) && !emerg_active) |-> dispatch_allow);

    // R4: a zero hold length switches the duty-cycle limiter off
    p_zero_hold_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd1 && hold_len == '0 && !emerg_active) |-> dispatch_allow);
endmodule

// File: tb/test_dispatch_throttle.sv
`timescale 1ns/1ps
module test_dispatch_throttle;
    localparam int CW = 16;
    localparam int NT = 2;
    localparam int ST = 8;
    localparam int IV = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic [CW-1:0] run_len = '0;
    logic [CW-1:0] hold_len = '0;
    logic          cap_src = 1'b0;
    logic [NT-1:0] disp_stb = '0;
    logic [NT-1:0] cmpl_stb = '0;
    logic          temp_crit = 1'b0;
    logic          temp_warn = 1'b0;
    logic          dispatch_allow, throttled_cycle, emerg_active, cap_reached;

    dispatch_throttle #(
        .CNT_W(CW), .NUM_THREADS(NT), .RAMP_STEPS(ST), .RAMP_INTERVAL(IV)
    ) i_dispatch_throttle (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .run_len(run_len),
        .hold_len(hold_len), .cap_src(cap_src), .disp_stb(disp_stb),
        .cmpl_stb(cmpl_stb), .temp_crit(temp_crit), .temp_warn(temp_warn),
        .dispatch_allow(dispatch_allow), .throttled_cycle(throttled_cycle),
        .emerg_active(emerg_active), .cap_reached(cap_reached)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // configuration applied at each falling edge
    int         c_mode = 0, c_m = 0, c_n = 0;
    bit         c_src = 0, c_crit = 0, c_warn = 0;
    logic [1:0] c_mask = 2'b11;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int rh_ph = 0, rh_c = 0, wc = 0, ic = 0;
    int em_st = 0, em_step = 1, em_ph = 0, em_tmr = 0;

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic one_cycle();
        bit m_allow, e_allow, m_reach;
        logic [1:0] s;
        int ev;
        @(negedge clk);
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mode_sel  = c_mode[1:0];
        run_len   = c_m[15:0];
        hold_len  = c_n[15:0];
        cap_src   = c_src;
        temp_crit = c_crit;
        temp_warn = c_warn;
        disp_stb  = lfsr[1:0] & c_mask;
        cmpl_stb  = lfsr[5:4] & c_mask;
        #1;
        case (c_mode)
            1:       m_allow = (c_n == 0) ? 1'b1 : (c_m == 0) ? 1'b0 : (rh_ph == 0);
            2:       m_allow = (c_n == 0) ? 1'b1 : (ic < c_m);
            default: m_allow = 1'b1;
        endcase
        m_reach = (c_mode == 2) && (c_n != 0) && (ic >= c_m);
        e_allow = (em_st == 0) ? 1'b1 : (em_ph >= ST - em_step);
        chk("dispatch_allow", dispatch_allow, m_allow && e_allow);
        chk("throttled_cycle(R11)", throttled_cycle, !(m_allow && e_allow));
        chk("emerg_active(R12)", emerg_active, em_st != 0);
        chk("cap_reached(R12)", cap_reached, m_reach);
        // duty-cycle model
        if (c_mode != 1 || c_m == 0 || c_n == 0) begin
            rh_ph = 0; rh_c = 0;
        end else if (rh_ph == 0) begin
            if (rh_c >= c_m - 1) begin rh_ph = 1; rh_c = 0; end else rh_c++;
        end else begin
            if (rh_c >= c_n - 1) begin rh_ph = 0; rh_c = 0; end else rh_c++;
        end
        // instruction-cap model
        s  = c_src ? cmpl_stb : disp_stb;
        ev = int'(s[0]) + int'(s[1]);
        if (c_mode != 2 || c_n == 0) begin
            wc = 0; ic = 0;
        end else if (wc >= c_n - 1) begin
            wc = 0; ic = 0;
        end else begin
            wc++;
            ic = (ic + ev > 65535) ? 65535 : ic + ev;
        end
        // thermal guard model
        if (em_st == 0) begin
            em_ph = 0;
            if (c_crit) begin em_st = 1; em_step = 1; em_tmr = 0; end
        end else begin
            em_ph = (em_ph + 1) % ST;
            if (em_st == 1) begin
                if (!c_crit && !c_warn) begin em_st = 2; em_tmr = 0; end
            end else if (c_crit) begin
                em_st = 1; em_step = 1; em_tmr = 0;
            end else if (!c_warn) begin
                if (em_tmr == IV - 1) begin
                    em_tmr = 0;
                    if (em_step == ST) begin em_st = 0; em_ph = 0; end
                    else em_step++;
                end else em_tmr++;
            end
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) one_cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        tag = "R1 reset";
        chk("dispatch_allow", dispatch_allow, 1'b1);
        chk("emerg_active", emerg_active, 1'b0);
        chk("cap_reached", cap_reached, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: off and reserved encodings
        tag = "R1"; c_mode = 0; c_m = 1; c_n = 1; run(20);
        c_mode = 3; run(20);
        // R2: basic duty cycle, strobes idle
        tag = "R2"; c_mode = 1; c_m = 3; c_n = 2; c_mask = 2'b00; run(30);
        // R3: strobes toggling must not change the cycle pattern
        tag = "R3"; c_mask = 2'b11; run(30);
        c_m = 40; c_n = 60; run(220);
        // R4: degenerate lengths and runtime rewrite
        tag = "R4"; c_m = 5; c_n = 0; run(20);
        c_m = 0; c_n = 4; run(20);
        c_m = 4; c_n = 6; run(13);
        c_m = 2; c_n = 3; run(20);
        // R5: instruction cap over a window
        tag = "R5"; c_mode = 2; c_src = 0; c_m = 4; c_n = 10; run(60);
        c_m = 1; c_n = 3; run(30);
        c_m = 2; c_n = 1; run(10);
        // R6: completion strobes as source, one thread only
        tag = "R6"; c_src = 1; c_m = 5; c_n = 12; run(60);
        c_mask = 2'b01; run(30);
        c_mask = 2'b11; c_src = 0; run(30);
        // R7: zero window and zero cap
        tag = "R7"; c_n = 0; c_m = 3; run(20);
        c_n = 5; c_m = 0; run(20);
        // R8: critical clamp
        tag = "R8"; c_mode = 0; c_crit = 1; run(40);
        // R9: ramp, warning freeze, critical pulse, full recovery
        tag = "R9"; c_crit = 0; c_warn = 1; run(20);
        c_warn = 0; run(40);
        c_warn = 1; run(20);
        c_warn = 0; run(30);
        c_crit = 1; run(5);
        c_crit = 0; run(200);
        // R10: programmed mode and guard combined
        tag = "R10"; c_mode = 1; c_m = 3; c_n = 1; c_crit = 1; run(30);
        c_crit = 0; run(150);
        c_mode = 2; c_m = 3; c_n = 6; c_crit = 1; run(20);
        c_crit = 0; run(150);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule